// File: doc/BRIEF.md
# Addressed Multidrop Serial Front End

This block sits between a byte receiver and a result register file in a peripheral that shares a single serial line with up to 31 others. Each peripheral has a 5-bit strapped address. The host first sends an address byte, and only the peripheral whose strapped address matches takes part in the traffic that follows. That peripheral stays the active one until the host sends an address byte naming a different peripheral. While unselected, the block stays silent and forwards nothing.

While selected, command bytes pass straight through to the conversion control logic. Request bytes are decoded into a selector that picks one result digit or the status byte. The block tells the register file which item was read, and then returns that item as a single formatted byte. Each digit goes out in its own byte, with a fixed `0011` upper nibble. The most significant position also carries the sign and overrange flags. Reading a full result therefore takes six requests and six responses.

Top module: `mdrop_front_end`

## Requirements
- R1: After reset the block is unselected and `cmd_valid`, `rd_req` and `tx_valid` are low.
- R2: A received byte with bits 7:5 equal to `100` is an address byte carrying an address in bits 4:0, with bit 4 as the MSB. When all five bits equal `hw_addr`, `selected` goes high one cycle after the byte. An address byte never produces a command, a request or a response.
- R3: `selected` changes only on an address byte. When selected, an address byte whose address differs from `hw_addr` clears `selected` one cycle later. A repeat of the matching address keeps the block selected.
- R4: While unselected, every non-address byte is ignored: no `cmd_valid`, no `rd_req` and no `tx_valid`.
- R5: While selected, a byte that is not an address byte and has bit 0 clear is a command. One cycle later, `cmd_valid` pulses for one cycle with `cmd_byte` equal to the received byte.
- R6: While selected, a byte with bit 0 set, bits 7:4 zero and selector bits 3:1 from `000` to `110` is a request. One cycle later, `rd_req` pulses with `rd_sel` equal to the selector. Values `000` to `101` name digits 0 to 5, and `110` names status.
- R7: A request for digit k (0 to 4) is answered two cycles after the request byte. `tx_valid` pulses and `tx_byte` is `0011` followed by `res_bcd[4k+3:4k]`.
- R8: A request for digit 5 is answered with `tx_byte` = `0011`, `res_pos` in bit 3 (1 = positive), `res_ovr` in bit 2, and `res_msd` in bits 1:0.
- R9: A status request (selector `110`) is answered with `tx_byte` equal to `status_in`.
- R10: A byte with bit 0 set that has selector `111`, or any of bits 7:4 set without being an address byte, is ignored. It produces no `rd_req`, no `tx_valid` and no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_byte` holds a new byte this cycle |
| hw_addr | input | 5 | Strapped peripheral address, bit 4 MSB |
| res_bcd | input | 20 | BCD digits 0..4, digit k in bits 4k+3:4k |
| res_msd | input | 2 | Most significant digit (digit 5) |
| res_pos | input | 1 | Result polarity, 1 = positive |
| res_ovr | input | 1 | Result overrange flag |
| status_in | input | 8 | Status byte from the register file |
| selected | output | 1 | This peripheral is the addressed one |
| cmd_valid | output | 1 | One-cycle strobe: command forwarded |
| cmd_byte | output | 8 | Forwarded command byte |
| rd_req | output | 1 | One-cycle strobe: item read from the register file |
| rd_sel | output | 3 | Item read: 0..5 digit, 6 status |
| tx_valid | output | 1 | One-cycle strobe: response byte ready |
| tx_byte | output | 8 | Formatted response byte |

## Verification
The bench uses the default parameters: six digit positions, which give a 3-bit selector with one reserved code, and a 5-bit address. With these values, every selector code can be reached, including the reserved one. The strap value is chosen so that an address differing only in its MSB is offered first, which exposes any comparison that drops bit 4. The digit values are all distinct, and both polarity and overrange combinations are driven, so a swapped nibble or flag shows up in the response byte.

// File: rtl/mdrop_pkg.sv
`timescale 1ns/1ps
package mdrop_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 5;
    localparam int NDIG    = 6;
    localparam int SEL_W   = $clog2(NDIG + 1);
    localparam int NIB     = 4;
    localparam int MSD_W   = 2;

    localparam logic [BYTE_W-ADDR_W-1:0] ADDR_TAG  = 3'b100;
    localparam logic [NIB-1:0]           DIGIT_TAG = 4'b0011;
    localparam logic [SEL_W-1:0]         SEL_STATUS = SEL_W'(NDIG);

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_ADDR = 2'd1,
        K_CMD  = 2'd2,
        K_REQ  = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [ADDR_W-1:0]  addr;
        logic [SEL_W-1:0]   sel;
        logic [BYTE_W-1:0]  raw;
    } rx_info_t;

    function automatic rx_info_t classify(input logic [BYTE_W-1:0] b);
        rx_info_t info;
        info.raw  = b;
        info.addr = b[ADDR_W-1:0];
        info.sel  = b[SEL_W:1];
        if (b[BYTE_W-1:ADDR_W] == ADDR_TAG) begin
            info.kind = K_ADDR;
        end else if (!b[0]) begin
            info.kind = K_CMD;
        end else if ((b[BYTE_W-1:SEL_W+1] == '0) && (b[SEL_W:1] <= SEL_STATUS)) begin
            info.kind = K_REQ;
        end else begin
            info.kind = K_NONE;
        end
        return info;
    endfunction

endpackage

// File: rtl/mdrop_classify.sv
`timescale 1ns/1ps
module mdrop_classify
    import mdrop_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    output rx_info_t          info
);

    always_comb begin
        info = classify(rx_byte);
    end

endmodule

// File: rtl/mdrop_select.sv
`timescale 1ns/1ps
module mdrop_select
    import mdrop_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_strobe,
    input  logic [AW-1:0] addr_seen,
    input  logic [AW-1:0] hw_addr,
    output logic          sel_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else if (addr_strobe) begin
            sel_q <= (addr_seen == hw_addr);
        end
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !addr_strobe |=> $stable(sel_q)); // R3

endmodule

// File: rtl/mdrop_format.sv
`timescale 1ns/1ps
module mdrop_format
    import mdrop_pkg::*;
#(
    parameter int ND = NDIG,
    parameter int NW = NIB,
    parameter int MW = MSD_W
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [(ND-1)*NW-1:0]  bcd,
    input  logic [MW-1:0]         msd,
    input  logic                  pos,
    input  logic                  ovr,
    input  logic [BYTE_W-1:0]     status,
    output logic [BYTE_W-1:0]     byte_o
);

    logic [BYTE_W-1:0] cand [ND];

    for (genvar g = 0; g < ND - 1; g++) begin : g_low
        assign cand[g] = {DIGIT_TAG, bcd[g*NW +: NW]};
    end
    assign cand[ND-1] = {DIGIT_TAG, pos, ovr, msd};

    always_comb begin
        byte_o = status;
        for (int i = 0; i < ND; i++) begin
            if (sel == SEL_W'(i)) begin
                byte_o = cand[i];
            end
        end
    end

endmodule

// File: rtl/mdrop_front_end.sv
`timescale 1ns/1ps
module mdrop_front_end
    import mdrop_pkg::*;
#(
    parameter int ND = NDIG,
    parameter int AW = ADDR_W,
    parameter int NW = NIB,
    parameter int MW = MSD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BYTE_W-1:0]     rx_byte,
    input  logic                  rx_valid,
    input  logic [AW-1:0]         hw_addr,
    input  logic [(ND-1)*NW-1:0]  res_bcd,
    input  logic [MW-1:0]         res_msd,
    input  logic                  res_pos,
    input  logic                  res_ovr,
    input  logic [BYTE_W-1:0]     status_in,
    output logic                  selected,
    output logic                  cmd_valid,
    output logic [BYTE_W-1:0]     cmd_byte,
    output logic                  rd_req,
    output logic [SEL_W-1:0]      rd_sel,
    output logic                  tx_valid,
    output logic [BYTE_W-1:0]     tx_byte
);

    rx_info_t           info;
    logic               sel_q;
    logic               addr_strobe;
    logic               take_cmd;
    logic               take_req;
    logic [BYTE_W-1:0]  fmt_byte;

    mdrop_classify u_classify (
        .rx_byte (rx_byte),
        .info    (info)
    );

    assign addr_strobe = rx_valid && (info.kind == K_ADDR);

    mdrop_select #(.AW(AW)) u_select (
        .clk         (clk),
        .rst         (rst),
        .addr_strobe (addr_strobe),
        .addr_seen   (info.addr),
        .hw_addr     (hw_addr),
        .sel_q       (sel_q)
    );

    assign take_cmd = rx_valid && sel_q && (info.kind == K_CMD);
    assign take_req = rx_valid && sel_q && (info.kind == K_REQ);

    // Stage 1: forwarded command and register-file read
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
            rd_req    <= 1'b0;
            rd_sel    <= '0;
        end else begin
            cmd_valid <= take_cmd;
            rd_req    <= take_req;
            if (take_cmd) cmd_byte <= info.raw;
            if (take_req) rd_sel   <= info.sel;
        end
    end

    mdrop_format #(.ND(ND), .NW(NW), .MW(MW)) u_format (
        .sel    (rd_sel),
        .bcd    (res_bcd),
        .msd    (res_msd),
        .pos    (res_pos),
        .ovr    (res_ovr),
        .status (status_in),
        .byte_o (fmt_byte)
    );

    // Stage 2: formatted response
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= rd_req;
            if (rd_req) tx_byte <= fmt_byte;
        end
    end

    assign selected = sel_q;

    AST_RD_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> selected); // R4
    AST_CMD_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> selected); // R4
    AST_CMD_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && rd_req)); // R5
    AST_RD_NOT_RESERVED: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_sel <= SEL_STATUS)); // R10
    AST_TX_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(rd_req)); // R7
    AST_TX_DIGIT_TAG: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && ($past(rd_sel) != SEL_STATUS)) |-> (tx_byte[7:4] == DIGIT_TAG)); // R7
    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid || $past(take_cmd)); // R5

endmodule

// File: tb/mdrop_front_end_tb.sv
`timescale 1ns/1ps
module mdrop_front_end_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_valid = 1'b0;
    logic [4:0]  hw_addr = 5'b10110;
    logic [19:0] res_bcd = 20'h50937;
    logic [1:0]  res_msd = 2'd2;
    logic        res_pos = 1'b1;
    logic        res_ovr = 1'b0;
    logic [7:0]  status_in = 8'h5A;
    logic        selected, cmd_valid, rd_req, tx_valid;
    logic [7:0]  cmd_byte, tx_byte;
    logic [2:0]  rd_sel;

    int total = 0;
    int bad = 0;

    logic       o_cmd, o_rd, o_tx;
    logic [7:0] o_cmdb, o_txb;
    logic [2:0] o_rsel;

    always #4 clk = ~clk;

    mdrop_front_end dut_i (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .hw_addr(hw_addr), .res_bcd(res_bcd), .res_msd(res_msd),
        .res_pos(res_pos), .res_ovr(res_ovr), .status_in(status_in),
        .selected(selected), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .rd_req(rd_req), .rd_sel(rd_sel), .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one byte and capture stage-1 and stage-2 outputs
    task automatic xfer(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        o_cmd = cmd_valid; o_cmdb = cmd_byte;
        o_rd = rd_req;     o_rsel = rd_sel;
        @(negedge clk);
        o_tx = tx_valid;   o_txb = tx_byte;
    endtask

    task automatic t_reset;
        chk("R1 selected", {7'b0, selected}, 8'h00);
        chk("R1 cmd_valid", {7'b0, cmd_valid}, 8'h00);
        chk("R1 rd_req", {7'b0, rd_req}, 8'h00);
        chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    endtask

    task automatic t_unselected;
        xfer(8'h02);
        chk("R4 cmd while unselected", {7'b0, o_cmd}, 8'h00);
        xfer(8'h01);
        chk("R4 rd while unselected", {7'b0, o_rd}, 8'h00);
        chk("R4 tx while unselected", {7'b0, o_tx}, 8'h00);
    endtask

    task automatic t_select;
        xfer(8'h86);
        chk("R2 msb mismatch", {7'b0, selected}, 8'h00);
        xfer(8'h96);
        chk("R2 match selects", {7'b0, selected}, 8'h01);
        chk("R2 address no cmd", {7'b0, o_cmd}, 8'h00);
        chk("R2 address no tx", {7'b0, o_tx}, 8'h00);
    endtask

    task automatic t_digits;
        logic [7:0] exp [5] = '{8'h37, 8'h33, 8'h39, 8'h30, 8'h35};
        for (int k = 0; k < 5; k++) begin
            xfer({4'b0000, 3'(k), 1'b1});
            chk("R6 rd_req", {7'b0, o_rd}, 8'h01);
            chk("R6 rd_sel", {5'b0, o_rsel}, 8'(k));
            chk("R7 tx_valid", {7'b0, o_tx}, 8'h01);
            chk("R7 digit byte", o_txb, exp[k]);
        end
    endtask

    task automatic t_digit5;
        xfer(8'h0B);
        chk("R8 tx_valid", {7'b0, o_tx}, 8'h01);
        chk("R8 pos msd2", o_txb, 8'h3A);
        res_pos = 1'b0; res_ovr = 1'b1; res_msd = 2'd1;
        xfer(8'h0B);
        chk("R8 neg ovr msd1", o_txb, 8'h35);
    endtask

    task automatic t_status;
        xfer(8'h0D);
        chk("R9 rd_sel", {5'b0, o_rsel}, 8'h06);
        chk("R9 status byte", o_txb, 8'h5A);
        status_in = 8'hC3;
        xfer(8'h0D);
        chk("R9 status byte 2", o_txb, 8'hC3);
    endtask

    task automatic t_reserved;
        xfer(8'h0F);
        chk("R10 sel 111 rd", {7'b0, o_rd}, 8'h00);
        chk("R10 sel 111 tx", {7'b0, o_tx}, 8'h00);
        xfer(8'h11);
        chk("R10 upper bits rd", {7'b0, o_rd}, 8'h00);
        chk("R10 upper bits tx", {7'b0, o_tx}, 8'h00);
        chk("R10 upper bits cmd", {7'b0, o_cmd}, 8'h00);
    endtask

    task automatic t_command;
        xfer(8'h28);
        chk("R5 cmd_valid", {7'b0, o_cmd}, 8'h01);
        chk("R5 cmd_byte", o_cmdb, 8'h28);
        chk("R5 no rd", {7'b0, o_rd}, 8'h00);
        chk("R5 pulse ends", {7'b0, cmd_valid}, 8'h00);
    endtask

    task automatic t_persist;
        chk("R3 still selected", {7'b0, selected}, 8'h01);
        xfer(8'h96);
        chk("R3 repeat address keeps", {7'b0, selected}, 8'h01);
        xfer(8'h95);
        chk("R3 other address clears", {7'b0, selected}, 8'h00);
        xfer(8'h01);
        chk("R4 rd after deselect", {7'b0, o_rd}, 8'h00);
        chk("R4 tx after deselect", {7'b0, o_tx}, 8'h00);
        xfer(8'h96);
        chk("R3 reselect", {7'b0, selected}, 8'h01);
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unselected();
        t_select();
        t_digits();
        t_digit5();
        t_status();
        t_reserved();
        t_command();
        t_persist();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule